// File: doc/BRIEF.md
# Dual-Width Host Bus Port for a Character Display Controller

This block sits between a microprocessor bus and the execution core of a character display controller. The host drives a register select line, a read/write line, an enable strobe and an 8-bit data bus. The port brings these into the core clock domain and acts on each falling edge of the enable strobe. It decodes the four register operations. Completed instruction or data bytes go to the execution core through a one-cycle strobe. On reads, the port returns either the status (busy flag plus address counter) or a read-ahead copy of the RAM byte at the current address.

The bus starts out 8 bits wide. A function-set instruction can narrow it to 4 bits, and then only the upper four data lines carry information. In that mode every access takes two enable cycles: the high nibble first, then the low nibble. The nibble phase also advances on status and data reads, so host and port never fall out of step. The read-ahead register is refilled after each address-load instruction and after each completed data read. For the refill after a read, the port first tells the core to advance its address.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the port is in 8-bit mode, the read-ahead register holds 0x00 and `busOe` is low.
- R2: An 8-bit write with select=0 and a nonzero byte raises `execStb` for exactly one cycle, with `execRs`=0 and that byte on `execByte`.
- R3: A write with select=1 raises `execStb` once, with `execRs`=1 and the written byte on `execByte`.
- R4: A read with select=0 returns `coreBusy` on bit 7 and `coreAddr` on bits 6..0. It produces neither `execStb` nor `readAdv`.
- R5: `busOe` is high only while the enable strobe is high and read/write=1. It is low during writes.
- R6: In 4-bit mode a write uses data lines 7..4 only, high nibble first. Lines 3..0 are ignored. One `execStb` follows the second nibble and none follows the first.
- R7: In 4-bit mode every read gives the high nibble of the selected byte on lines 7..4 first and the low nibble second, with lines 3..0 at zero. Status reads advance the nibble phase like any other access, so the next write stays aligned.
- R8: An instruction whose bits 7..5 are 001 is a function set. Its bit 4 = 0 selects 4-bit mode and resets the nibble phase to high; bit 4 = 1 selects 8-bit mode.
- R9: An all-zero instruction byte is a no-operation and produces no `execStb`.
- R10: An instruction with bit 7 = 1, or with bits 7..6 = 01, loads an address. Once the core has updated `coreAddr`, the read-ahead register picks up `ramRdData` for the new address, ready for the next data read.
- R11: A completed data read (select=1) returns the read-ahead byte and pulses `readAdv` once. The register then reloads with the byte at the advanced address.
- R12: In 4-bit mode `readAdv` pulses only after the second nibble of a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busRs | input | 1 | Register select: 0 instruction/status, 1 data |
| busRw | input | 1 | 1 read, 0 write |
| busE | input | 1 | Enable strobe; transfer acts on its falling edge |
| busDin | input | 8 | Data bus from the host |
| busDout | output | 8 | Data bus toward the host |
| busOe | output | 1 | Data bus output enable |
| execStb | output | 1 | One-cycle strobe for a completed instruction or data byte |
| execRs | output | 1 | Kind of the strobed byte: 0 instruction, 1 data |
| execByte | output | 8 | Completed byte |
| readAdv | output | 1 | One-cycle request to advance the address after a data read |
| coreBusy | input | 1 | Busy flag from the core |
| coreAddr | input | 7 | Address counter from the core |
| ramRdData | input | 8 | RAM byte at `coreAddr` |

## Verification
After the enable strobe falls at the pins, `execStb`, `readAdv` and `execByte` change at the third rising clock edge: two synchronizer stages plus the edge-detect register. The read-ahead register loads two edges after that. Read data and status are combinational from registered state, so they are sampled mid-cycle near the end of the high phase of the enable strobe. Strobe counts and strobed bytes are checked eight cycles after the enable strobe falls, by which point every pipeline stage and the prefetch have settled.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // control-to-datapath strobes, all valid for one cycle
  typedef struct packed {
    logic loadHi;   // store the first (high) nibble of a 4-bit write
    logic capture;  // a full write byte is assembled this cycle
    logic fetch;    // start a read-ahead refill
  } hpStrobe_t;

  localparam int FUNC_DL_BIT = 4;          // bus width select in a function set
  localparam logic [2:0] FUNC_PREFIX = 3'b001;
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busRs,
  input  logic          busRw,
  input  logic          busE,
  input  logic [DW-1:0] asmByte,
  output hpStrobe_t     st,
  output logic          mode4,
  output logic          phaseHigh,
  output logic          execStb,
  output logic          execRs,
  output logic          readAdv
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] eSh, rsSh, rwSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eSh[0]  <= 1'b0;
      rsSh[0] <= 1'b0;
      rwSh[0] <= 1'b0;
    end else begin
      eSh[0]  <= busE;
      rsSh[0] <= busRs;
      rwSh[0] <= busRw;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        eSh[i]  <= 1'b0;
        rsSh[i] <= 1'b0;
        rwSh[i] <= 1'b0;
      end else begin
        eSh[i]  <= eSh[i-1];
        rsSh[i] <= rsSh[i-1];
        rwSh[i] <= rwSh[i-1];
      end
    end
  end

  logic fall, rsL, rwL, complete, funcSet, addrSet;
  logic doInstr, doData, doRead;

  always_comb begin
    fall     = eSh[DEPTH-1] & ~eSh[DEPTH-2];
    rsL      = rsSh[DEPTH-1];
    rwL      = rwSh[DEPTH-1];
    complete = ~mode4 | ~phaseHigh;
    funcSet  = (asmByte[DW-1:DW-3] == FUNC_PREFIX);
    addrSet  = asmByte[DW-1] | (asmByte[DW-1:DW-2] == 2'b01);

    st.loadHi  = fall & ~rwL & ~complete;
    st.capture = fall & ~rwL & complete;
    doInstr    = st.capture & ~rsL & (asmByte != '0);
    doData     = st.capture & rsL;
    doRead     = fall & rwL & rsL & complete;
    st.fetch   = (doInstr & addrSet) | doRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execStb   <= 1'b0;
      execRs    <= 1'b0;
      readAdv   <= 1'b0;
      mode4     <= 1'b0;
      phaseHigh <= 1'b1;
    end else begin
      execStb <= doInstr | doData;
      readAdv <= doRead;
      if (st.capture) execRs <= rsL;
      if (doInstr && funcSet) mode4 <= ~asmByte[FUNC_DL_BIT];
      if (doInstr && funcSet && !asmByte[FUNC_DL_BIT]) phaseHigh <= 1'b1;
      else if (fall && mode4) phaseHigh <= ~phaseHigh;
    end
  end

  // R2: a completed byte is announced for one cycle only
  p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> !execStb);
  // R12: a read never coincides with a byte hand-off
  p_kind_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(execStb && readAdv));
  // R8: outside 4-bit mode the phase sits on the high nibble
  p_phase8_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mode4 |-> phaseHigh);
endmodule

// File: rtl/hp_data.sv
module hp_data
  import hp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FETCH_LAT = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] busDin,
  input  logic          busRs,
  input  logic          busRw,
  input  logic          busE,
  input  hpStrobe_t     st,
  input  logic          mode4,
  input  logic          phaseHigh,
  input  logic          execStb,
  input  logic          execRs,
  input  logic          readAdv,
  input  logic          coreBusy,
  input  logic [DW-2:0] coreAddr,
  input  logic [DW-1:0] ramRdData,
  output logic [DW-1:0] asmByte,
  output logic [DW-1:0] execByte,
  output logic [DW-1:0] busDout,
  output logic          busOe
);
  localparam int DEPTH = SYNC_STAGES + 1;
  localparam int NW = DW / 2;
  localparam int CW = $clog2(FETCH_LAT + 1);

  logic [DW-1:0] dinSh [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dinSh[0] <= '0;
    else       dinSh[0] <= busDin;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_dsync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dinSh[i] <= '0;
      else       dinSh[i] <= dinSh[i-1];
    end
  end

  logic [NW-1:0] hiNib;
  logic [DW-1:0] readReg, selByte;
  logic [CW-1:0] fetchCnt;
  logic [DW-1:0] dinL;

  always_comb begin
    dinL    = dinSh[DEPTH-1];
    asmByte = mode4 ? {hiNib, dinL[DW-1:NW]} : dinL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib    <= '0;
      execByte <= '0;
    end else begin
      if (st.loadHi)  hiNib    <= dinL[DW-1:NW];
      if (st.capture) execByte <= asmByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchCnt <= '0;
      readReg  <= '0;
    end else if (st.fetch) begin
      fetchCnt <= CW'(FETCH_LAT);
    end else if (fetchCnt == CW'(1)) begin
      fetchCnt <= '0;
      readReg  <= ramRdData;
    end else if (fetchCnt != '0) begin
      fetchCnt <= fetchCnt - CW'(1);
    end
  end

  always_comb begin
    selByte = busRs ? readReg : {coreBusy, coreAddr};
    if (mode4)
      busDout = {(phaseHigh ? selByte[DW-1:NW] : selByte[NW-1:0]), {NW{1'b0}}};
    else
      busDout = selByte;
    busOe = busE & busRw;
  end

  // R11: a completed data read starts a full-length refill
  p_adv_fetch_r11: assert property (@(posedge clk) disable iff (!rstN)
    readAdv |-> fetchCnt == CW'(FETCH_LAT));
  // R9: an instruction hand-off never carries the all-zero code
  p_nop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && !execRs) |-> execByte != '0);
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FETCH_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRs,
  input  logic       busRw,
  input  logic       busE,
  input  logic [7:0] busDin,
  output logic [7:0] busDout,
  output logic       busOe,
  output logic       execStb,
  output logic       execRs,
  output logic [7:0] execByte,
  output logic       readAdv,
  input  logic       coreBusy,
  input  logic [6:0] coreAddr,
  input  logic [7:0] ramRdData
);
  localparam int DW = 8;

  hpStrobe_t     st;
  logic          mode4, phaseHigh;
  logic [DW-1:0] asmByte;

  hp_ctrl #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw), .busE(busE),
    .asmByte(asmByte), .st(st), .mode4(mode4), .phaseHigh(phaseHigh),
    .execStb(execStb), .execRs(execRs), .readAdv(readAdv)
  );

  hp_data #(.DW(DW), .SYNC_STAGES(SYNC_STAGES), .FETCH_LAT(FETCH_LAT)) u_data (
    .clk(clk), .rstN(rstN), .busDin(busDin), .busRs(busRs), .busRw(busRw),
    .busE(busE), .st(st), .mode4(mode4), .phaseHigh(phaseHigh),
    .execStb(execStb), .execRs(execRs), .readAdv(readAdv),
    .coreBusy(coreBusy), .coreAddr(coreAddr), .ramRdData(ramRdData),
    .asmByte(asmByte), .execByte(execByte), .busDout(busDout), .busOe(busOe)
  );
endmodule

// File: tb/sim_lcd_host_port.sv
`timescale 1ns/1ps
module sim_lcd_host_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRs = 1'b0, busRw = 1'b0, busE = 1'b0;
  logic [7:0] busDin = 8'h00;
  logic [7:0] busDout;
  logic busOe, execStb, execRs, readAdv;
  logic [7:0] execByte;
  logic coreBusy = 1'b0;
  logic [6:0] mAddr;
  logic [7:0] mem [128];
  logic [7:0] ramRdData;

  int tests = 0, fails = 0;
  int stbCnt = 0, advCnt = 0;
  logic [7:0] lastByte;
  logic lastRs;

  always #4 clk = ~clk;

  lcd_host_port u0 (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw), .busE(busE),
    .busDin(busDin), .busDout(busDout), .busOe(busOe), .execStb(execStb),
    .execRs(execRs), .execByte(execByte), .readAdv(readAdv),
    .coreBusy(coreBusy), .coreAddr(mAddr), .ramRdData(ramRdData)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'(i * 7 + 3);
  endfunction

  // execution core model
  assign ramRdData = mem[mAddr];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAddr <= '0;
    end else begin
      if (execStb) begin
        stbCnt   <= stbCnt + 1;
        lastByte <= execByte;
        lastRs   <= execRs;
        if (execRs) begin
          mem[mAddr] <= execByte;
          mAddr <= mAddr + 7'd1;
        end else if (execByte[7]) begin
          mAddr <= execByte[6:0];
        end else if (execByte[7:6] == 2'b01) begin
          mAddr <= {2'b00, execByte[4:0]};
        end
      end
      if (readAdv) begin
        advCnt <= advCnt + 1;
        mAddr  <= mAddr + 7'd1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic rs, input logic rw, input logic [7:0] d,
                          output logic [7:0] q, output logic oe);
    @(negedge clk);
    busRs = rs; busRw = rw; busDin = d;
    repeat (2) @(negedge clk);
    busE = 1'b1;
    repeat (4) @(negedge clk);
    q = busDout; oe = busOe;
    busE = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] q; logic oe;
    check("R1 oe idle", busOe, 0);
    busCycle(0, 1, 8'h00, q, oe);
    check("R4 status after reset", q, 8'h00);
    check("R5 oe on read", oe, 1);
    busCycle(1, 1, 8'h00, q, oe);
    check("R1 read-ahead reset value", q, 8'h00);
    check("R11 advance pulse", advCnt, 1);
  endtask

  task automatic t_instr8;
    logic [7:0] q; logic oe; int s0;
    s0 = stbCnt;
    busCycle(0, 0, 8'h0C, q, oe);
    check("R2 one strobe", stbCnt, s0 + 1);
    check("R2 byte", lastByte, 8'h0C);
    check("R2 kind", lastRs, 0);
    check("R5 oe low on write", oe, 0);
    busCycle(0, 0, 8'h00, q, oe);
    check("R9 nop no strobe", stbCnt, s0 + 1);
  endtask

  task automatic t_prefetch;
    logic [7:0] q; logic oe; int a0;
    busCycle(0, 0, 8'h85, q, oe);
    busCycle(1, 1, 8'h00, q, oe);
    check("R10 dd address fetch", q, initVal(5));
    busCycle(1, 1, 8'h00, q, oe);
    check("R11 next byte", q, initVal(6));
    a0 = stbCnt;
    busCycle(0, 1, 8'h00, q, oe);
    check("R4 address", q, 8'h07);
    coreBusy = 1'b1;
    busCycle(0, 1, 8'h00, q, oe);
    check("R4 busy bit", q, 8'h87);
    coreBusy = 1'b0;
    check("R4 no strobe on status", stbCnt, a0);
    busCycle(0, 0, 8'h43, q, oe);
    busCycle(1, 1, 8'h00, q, oe);
    check("R10 cg address fetch", q, initVal(3));
  endtask

  task automatic t_data8;
    logic [7:0] q; logic oe; int s0;
    s0 = stbCnt;
    busCycle(1, 0, 8'h3C, q, oe);
    check("R3 strobe", stbCnt, s0 + 1);
    check("R3 byte", lastByte, 8'h3C);
    check("R3 kind", lastRs, 1);
  endtask

  task automatic t_mode4;
    logic [7:0] q; logic oe; int s0, a0;
    busCycle(0, 0, 8'h20, q, oe);
    check("R8 func set strobed", lastByte, 8'h20);
    s0 = stbCnt;
    busCycle(0, 0, 8'h8F, q, oe);
    check("R6 no strobe after high nibble", stbCnt, s0);
    busCycle(0, 0, 8'hAF, q, oe);
    check("R6 one strobe after low nibble", stbCnt, s0 + 1);
    check("R6 assembled byte", lastByte, 8'h8A);
    a0 = advCnt;
    busCycle(0, 1, 8'h00, q, oe);
    check("R7 status high nibble", q, 8'h00);
    busCycle(0, 1, 8'h00, q, oe);
    check("R7 status low nibble", q, 8'hA0);
    busCycle(1, 1, 8'h00, q, oe);
    check("R7 data high nibble", q, {initVal(10) >> 4, 4'h0});
    check("R12 no advance mid read", advCnt, a0);
    busCycle(1, 1, 8'h00, q, oe);
    check("R7 data low nibble", q, {initVal(10) & 8'h0F, 4'h0} & 8'hF0);
    check("R12 advance after read", advCnt, a0 + 1);
    busCycle(0, 0, 8'h00, q, oe);
    busCycle(0, 0, 8'h10, q, oe);
    check("R7 aligned after reads", lastByte, 8'h01);
  endtask

  task automatic t_back8;
    logic [7:0] q; logic oe;
    busCycle(0, 0, 8'h30, q, oe);
    busCycle(0, 0, 8'h00, q, oe);
    check("R8 func set in 4-bit", lastByte, 8'h30);
    busCycle(0, 0, 8'h0F, q, oe);
    check("R8 back to 8-bit", lastByte, 8'h0F);
    busCycle(0, 1, 8'h00, q, oe);
    check("R8 full status byte", q, 8'h0B);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = initVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_instr8();
    t_prefetch();
    t_data8();
    t_mode4();
    t_back8();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule